// File: doc/BRIEF.md
# Text Glyph Row Serializer

This block turns one text cell into its pixels for a single scanline. A cell arrives as a character code, a row number within the cell, a mono/colour flag and a 2-bit font bank. The block fetches the matching glyph byte from an external synchronous font ROM and shifts the pixels out one at a time, MSB first, on each pixel-clock enable. A mono cell is nine pixels wide and a colour cell eight.

Cells enter through a valid/ready stream. A single holding slot sits between the ROM fetch and the shifter. The producer may hold `cell_valid` high for as long as it likes. A transfer takes place on a cycle where `cell_valid` and `cell_ready` are both high. The producer must keep the cell fields stable until that transfer happens. `cell_ready` falls while a ROM read is in flight, and it stays low while a fetched byte is waiting that the shifter does not take in the same cycle. If the shifter reaches the end of a cell and no byte is waiting, it shifts out an empty cell.

Top module: `glyph_row_serializer`

## Requirements
- R1: `cell_ready` is high exactly when no ROM read is in flight and the holding slot is either empty or being taken by the shifter in that cycle. `rom_rd` is high exactly in the cycles where `cell_valid` and `cell_ready` are both high.
- R2: On a transfer, `rom_addr` is {bank[1:0], not mono, code[7:0], row field}, which is 15 bits in total. In mono mode the row field is row[3:0], so rows 16 to 31 wrap onto rows 0 to 15. In colour mode the row field is {0, row[2:0]}, so rows 8 to 15 reuse rows 0 to 7.
- R3: The ROM answers one cycle after `rom_rd`. The block captures `rom_data` in that cycle, and the fetched byte is ready for the next cell load.
- R4: Pixels leave MSB first. There is one new pixel after each clock edge where `pix_en` is high. While `pix_en` is low, the pixel output holds its value.
- R5: A mono cell lasts 9 pixel enables and a colour cell lasts 8. The next cell loads on the enable that follows the last pixel of the current cell.
- R6: The ninth pixel of a mono cell repeats glyph bit 0 (the eighth pixel) only for codes 176 to 223. For every other code it is 0.
- R7: While `blank` is high, `pix_out` is 0. Blanking has no effect on shifting.
- R8: If no fetched byte is waiting when a cell ends, an 8-pixel cell of zeros is shifted out.
- R9: After reset, `pix_out` is 0 and `cell_ready` is 1. The first `pix_en` loads the first cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_valid | input | 1 | Cell offered |
| cell_ready | output | 1 | Cell accepted this cycle if valid |
| cell_code | input | 8 | Character code |
| cell_row | input | 5 | Scanline within the cell |
| cell_mono | input | 1 | 1 = mono 9-pixel cell, 0 = colour 8-pixel cell |
| cell_bank | input | 2 | Font bank select |
| rom_rd | output | 1 | Font ROM read strobe |
| rom_addr | output | 15 | Font ROM byte address |
| rom_data | input | 8 | Font ROM data, one cycle after the read |
| pix_en | input | 1 | Pixel clock enable |
| blank | input | 1 | Forces the pixel dark |
| pix_out | output | 1 | Serial pixel |

## Verification
Two situations are hard to reach from the ports. The first is a transfer that lands on the same cycle the shifter takes the held byte. The second is a cell that ends with nothing fetched. Each needs a particular alignment between the producer's `cell_valid` and sparse `pix_en` pulses. The random phase varies the density of both signals, which makes same-cycle takes and underruns occur often. Directed phases then stop the producer outright, and also run the boundary codes 175, 176, 223 and 224 in mono mode with row numbers that wrap.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  localparam int GLYPH_BITS = 8;
  localparam int ROW_FIELD_W = 4;

  typedef logic [GLYPH_BITS-1:0] glyph_byte_t;

  typedef struct packed {
    glyph_byte_t bits;
    logic        ninth_on;
    logic        mono;
  } glyph_slot_t;
endpackage

// File: rtl/glyph_addr.sv
module glyph_addr #(
  parameter int CODE_W = 8,
  parameter int ROW_W  = 5,
  parameter int BANK_W = 2,
  parameter int ADDR_W = BANK_W + 1 + CODE_W + glyph_pkg::ROW_FIELD_W
) (
  input  logic [CODE_W-1:0] code,
  input  logic [ROW_W-1:0]  row,
  input  logic              mono,
  input  logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr
);
  localparam int RF = glyph_pkg::ROW_FIELD_W;
  logic [RF-1:0] row_field;

  // mono keeps 16 distinct rows, colour keeps 8 (upper half folds down)
  always_comb begin
    if (mono) row_field = row[RF-1:0];
    else      row_field = {1'b0, row[RF-2:0]};
  end

  assign addr = {bank, ~mono, code, row_field};
endmodule

// File: rtl/glyph_fetch.sv
module glyph_fetch
  import glyph_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int ROW_W   = 5,
  parameter int BANK_W  = 2,
  parameter int ADDR_W  = 15,
  parameter int LINE_LO = 176,
  parameter int LINE_HI = 223
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_valid,
  output logic              cell_ready,
  input  logic [CODE_W-1:0] cell_code,
  input  logic [ROW_W-1:0]  cell_row,
  input  logic              cell_mono,
  input  logic [BANK_W-1:0] cell_bank,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  input  glyph_byte_t       rom_data,
  input  logic              take,
  output glyph_slot_t       slot,
  output logic              slot_valid
);
  logic pend;
  logic pend_ninth, pend_mono;
  logic line_code;

  glyph_addr #(.CODE_W(CODE_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_addr (
    .code(cell_code), .row(cell_row), .mono(cell_mono), .bank(cell_bank), .addr(rom_addr)
  );

  assign line_code  = (cell_code >= CODE_W'(LINE_LO)) && (cell_code <= CODE_W'(LINE_HI));
  assign cell_ready = !pend && (!slot_valid || take);
  assign rom_rd     = cell_valid && cell_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      pend_ninth <= 1'b0;
      pend_mono  <= 1'b0;
      slot_valid <= 1'b0;
      slot       <= '0;
    end else begin
      pend <= rom_rd;
      if (rom_rd) begin
        pend_ninth <= cell_mono && line_code;
        pend_mono  <= cell_mono;
      end
      if (pend) begin
        slot.bits     <= rom_data;
        slot.ninth_on <= pend_ninth;
        slot.mono     <= pend_mono;
        slot_valid    <= 1'b1;
      end else if (take) begin
        slot_valid <= 1'b0;
      end
    end
  end

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |=> !rom_rd); // R1
  AST_DATA_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |=> ##1 slot_valid); // R3
  AST_SLOT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !pend) |=> !slot_valid); // R1
endmodule

// File: rtl/glyph_shifter.sv
module glyph_shifter
  import glyph_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_en,
  input  logic        blank,
  input  glyph_slot_t slot,
  input  logic        slot_valid,
  output logic        take,
  output logic        pix_out
);
  localparam int SH_W = GLYPH_BITS + 1;
  localparam logic [3:0] LAST_COLOUR = 4'(GLYPH_BITS - 1);
  localparam logic [3:0] LAST_MONO   = 4'(GLYPH_BITS);

  logic [SH_W-1:0] shreg;
  logic [3:0]      pos, last;

  assign take    = pix_en && (pos == last);
  assign pix_out = shreg[SH_W-1] & ~blank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      pos   <= LAST_COLOUR;
      last  <= LAST_COLOUR;
    end else if (take) begin
      pos <= '0;
      if (slot_valid) begin
        shreg <= {slot.bits, slot.ninth_on & slot.bits[0]};
        last  <= slot.mono ? LAST_MONO : LAST_COLOUR;
      end else begin
        shreg <= '0;
        last  <= LAST_COLOUR;
      end
    end else if (pix_en) begin
      shreg <= {shreg[SH_W-2:0], 1'b0};
      pos   <= pos + 4'd1;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(shreg[SH_W-1])); // R4
  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= last); // R5
endmodule

// File: rtl/glyph_row_serializer.sv
module glyph_row_serializer #(
  parameter int CODE_W  = 8,
  parameter int ROW_W   = 5,
  parameter int BANK_W  = 2,
  parameter int LINE_LO = 176,
  parameter int LINE_HI = 223,
  localparam int ADDR_W = BANK_W + 1 + CODE_W + glyph_pkg::ROW_FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_valid,
  output logic              cell_ready,
  input  logic [CODE_W-1:0] cell_code,
  input  logic [ROW_W-1:0]  cell_row,
  input  logic              cell_mono,
  input  logic [BANK_W-1:0] cell_bank,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [7:0]        rom_data,
  input  logic              pix_en,
  input  logic              blank,
  output logic              pix_out
);
  glyph_pkg::glyph_slot_t slot;
  logic slot_valid, take;

  glyph_fetch #(.CODE_W(CODE_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
                .LINE_LO(LINE_LO), .LINE_HI(LINE_HI)) u_fetch (
    .clk(clk), .rst_n(rst_n), .cell_valid(cell_valid), .cell_ready(cell_ready),
    .cell_code(cell_code), .cell_row(cell_row), .cell_mono(cell_mono), .cell_bank(cell_bank),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
    .take(take), .slot(slot), .slot_valid(slot_valid)
  );

  glyph_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .blank(blank),
    .slot(slot), .slot_valid(slot_valid), .take(take), .pix_out(pix_out)
  );

  AST_BANK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |-> (rom_addr[ADDR_W-1 -: BANK_W] == cell_bank)); // R2
endmodule

// File: tb/tb_glyph_row_serializer.sv
module tb_glyph_row_serializer;
  localparam int CLK_P = 10;
  localparam int HALF  = CLK_P / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cell_valid = 1'b0, cell_mono = 1'b0, pix_en = 1'b0, blank = 1'b0;
  logic [7:0] cell_code = '0;
  logic [4:0] cell_row = '0;
  logic [1:0] cell_bank = '0;
  logic cell_ready, rom_rd, pix_out;
  logic [14:0] rom_addr;
  logic [7:0] rom_q = '0;

  int errors = 0, checks = 0;
  string phase_tag = "R4";
  int pe_pct = 100, bl_pct = 0;
  bit hs_seen = 0;

  // model state
  logic [8:0] m_sh; logic [3:0] m_pos, m_last;
  logic m_pend, m_hv; logic [8:0] m_pend_pat, m_hold; logic [3:0] m_pend_last, m_hold_last;

  glyph_row_serializer dut (
    .clk(clk), .rst_n(rst_n), .cell_valid(cell_valid), .cell_ready(cell_ready),
    .cell_code(cell_code), .cell_row(cell_row), .cell_mono(cell_mono), .cell_bank(cell_bank),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_q),
    .pix_en(pix_en), .blank(blank), .pix_out(pix_out)
  );

  always #HALF clk = ~clk;

  function automatic logic [7:0] romfn(logic [14:0] a);
    return 8'(a[7:0] ^ {a[14:8], 1'b1} ^ (a[11:4] * 8'd37));
  endfunction

  function automatic logic [14:0] exp_addr(logic [7:0] c, logic [4:0] r, logic m, logic [1:0] b);
    return {b, ~m, c, m ? r[3:0] : {1'b0, r[2:0]}};
  endfunction

  always @(posedge clk) if (rom_rd) rom_q <= romfn(rom_addr);

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model, sampled just before each rising edge
  always begin
    @(negedge clk); #(HALF-1);
    hs_seen = 0;
    if (!rst_n) begin
      m_sh = '0; m_pos = 7; m_last = 7; m_pend = 0; m_hv = 0;
      m_pend_pat = '0; m_hold = '0; m_pend_last = 7; m_hold_last = 7;
    end else begin
      bit consume, exp_ready, hs;
      logic [7:0] by;
      chk(pix_out === (m_sh[8] & ~blank), phase_tag, "pix_out", pix_out, m_sh[8] & ~blank);
      consume = pix_en && (m_pos == m_last);
      exp_ready = !m_pend && (!m_hv || consume);
      chk(cell_ready === exp_ready, "R1", "cell_ready", cell_ready, exp_ready);
      hs = cell_valid && exp_ready;
      chk(rom_rd === hs, "R1", "rom_rd", rom_rd, hs);
      if (hs) chk(rom_addr === exp_addr(cell_code, cell_row, cell_mono, cell_bank), "R2",
                  "rom_addr", rom_addr, exp_addr(cell_code, cell_row, cell_mono, cell_bank));
      hs_seen = hs;
      // advance shifter
      if (consume) begin
        m_pos = 0;
        if (m_hv) begin m_sh = m_hold; m_last = m_hold_last; end
        else begin m_sh = '0; m_last = 7; end
      end else if (pix_en) begin
        m_sh = {m_sh[7:0], 1'b0}; m_pos = m_pos + 1;
      end
      // advance slot (R3: byte available the cycle after the read)
      if (m_pend) begin m_hv = 1; m_hold = m_pend_pat; m_hold_last = m_pend_last; end
      else if (consume) m_hv = 0;
      m_pend = hs;
      if (hs) begin
        by = romfn(exp_addr(cell_code, cell_row, cell_mono, cell_bank));
        m_pend_pat = {by, cell_mono && cell_code >= 176 && cell_code <= 223 && by[0]};
        m_pend_last = cell_mono ? 4'd8 : 4'd7;
      end
    end
  end

  // pixel enable and blanking drivers
  always @(negedge clk) begin
    pix_en <= ($urandom_range(99) < pe_pct);
    blank  <= ($urandom_range(99) < bl_pct);
  end

  task automatic send(logic [7:0] c, logic [4:0] r, logic m, logic [1:0] b);
    @(negedge clk);
    cell_valid = 1; cell_code = c; cell_row = r; cell_mono = m; cell_bank = b;
    do @(posedge clk); while (!hs_seen);
    @(negedge clk); cell_valid = 0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(pix_out === 1'b0, "R9", "reset pix_out", pix_out, 0);
    chk(cell_ready === 1'b1, "R9", "reset ready", cell_ready, 1);
    chk(rom_rd === 1'b0, "R9", "reset rom_rd", rom_rd, 0);
    // R6 boundary codes in mono, pixel enables every cycle
    phase_tag = "R6"; pe_pct = 100;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] c;
      c = (k == 0) ? 8'd175 : (k == 1) ? 8'd176 : (k == 2) ? 8'd223 : 8'd224;
      for (int r = 0; r < 16; r++)
        if (romfn(exp_addr(c, 5'(r), 1'b1, 2'd1))[0]) begin send(c, 5'(r), 1'b1, 2'd1); break; end
    end
    // R2 row wrap in mono and fold in colour
    phase_tag = "R5";
    send(8'd65, 5'd20, 1'b1, 2'd3);
    send(8'd65, 5'd12, 1'b0, 2'd2);
    send(8'd200, 5'd9, 1'b0, 2'd0);
    // R8 underrun: producer idles
    phase_tag = "R8";
    repeat (40) @(negedge clk);
    // R7 blanking over live cells
    phase_tag = "R7"; bl_pct = 50;
    for (int i = 0; i < 20; i++) send(8'($urandom), 5'($urandom), 1'($urandom), 2'($urandom));
    // R4 random mix with sparse enables
    phase_tag = "R4";
    for (int i = 0; i < 1500; i++) begin
      pe_pct = (i % 300 < 150) ? 40 : 95;
      bl_pct = 10;
      send(($urandom_range(1) != 0) ? 8'($urandom_range(230, 170)) : 8'($urandom),
           5'($urandom), 1'($urandom), 2'($urandom));
      if ($urandom_range(9) == 0) repeat ($urandom_range(20)) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule